// File: doc/BRIEF.md
# Deblocking Boundary Strength Decision Unit

This unit decides how strongly an in-loop deblocking filter treats each edge between 4x4 sub-blocks of a 16x16 luma macroblock. It handles one edge direction per job: either the four vertical edges, running from the left macroblock boundary inwards, or the four horizontal edges, running from the top boundary downwards. Each edge is cut into four segments of four pixel edges. Every pixel edge in a segment has the same strength, so the unit produces one 3-bit code per segment, 16 codes per job. Chroma edges reuse the code of the matching luma segment, so no separate chroma result exists.

A job starts with a one-cycle `start` while the unit is idle. The unit registers the attributes of the sixteen current sub-blocks, of the four neighbour sub-blocks across the macroblock boundary, the direction, and the availability of the one neighbour macroblock that direction uses: the left one for vertical edges, the upper one for horizontal edges. Availability is resolved once per job. The unit then evaluates one edge per cycle, with all four segments in parallel, and presents the packed result with a one-cycle `done`. Only intra and single-reference predicted pictures are handled, so each sub-block carries one reference index and one motion vector.

Top module: `bs_decision_unit`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done` and every bit of `bs_out` are 0.
- R2: A `start` sampled while idle sets `busy` at that edge. Four clock edges later `busy` falls and `done` is high for exactly one cycle. `bs_out` changes only when `done` rises and holds its value until the next `done`.
- R3: A `start` sampled while `busy` is 1 is ignored. The running job finishes on time with the data captured at its own start.
- R4: Layout: sub-block n has row y = n/4 and column x = n%4. `dir`=0 selects vertical edges, with P on the left and Q on the right, and neighbour slot j is the left macroblock's sub-block in row j. `dir`=1 selects horizontal edges, with P above and Q below, and neighbour slot j is the upper macroblock's sub-block in column j. Edge e (0 = macroblock boundary) and segment s give slot k = 4e+s, held in `bs_out[3k+2:3k]`. For vertical edges s is the row and Q = sub-block 4s+e. For horizontal edges s is the column and Q = sub-block 4e+s.
- R5: A segment on the macroblock boundary (e = 0) with an available neighbour and either side intra coded gets code 4.
- R6: An internal segment (e > 0) with either side intra coded gets code 3. Code 4 never appears in slots 4..15.
- R7: With neither side intra and either side holding nonzero coefficients, the code is 2.
- R8: Otherwise, if the two reference indices differ, the code is 1.
- R9: Otherwise, the code is 1 when the horizontal or vertical motion-vector components differ by 4 or more quarter-samples, in either sign. A difference of 3 gives code 0, and so does equality.
- R10: When the neighbour macroblock for the chosen direction is unavailable (`left_avail`=0 for `dir`=0, `top_avail`=0 for `dir`=1), slots 0..3 are 0 whatever the attributes. The flag of the other direction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job when idle |
| dir | input | 1 | 0 vertical edges, 1 horizontal edges |
| left_avail | input | 1 | Left neighbour macroblock exists |
| top_avail | input | 1 | Upper neighbour macroblock exists |
| cur_intra | input | 16 | Intra flag per current sub-block |
| cur_nz | input | 16 | Nonzero-coefficient flag per current sub-block |
| cur_ref | input | 64 | Reference index per current sub-block, 4 bits each |
| cur_mvx | input | 192 | Horizontal MV per current sub-block, 12-bit signed each |
| cur_mvy | input | 192 | Vertical MV per current sub-block, 12-bit signed each |
| nb_intra | input | 4 | Intra flag per neighbour sub-block |
| nb_nz | input | 4 | Nonzero-coefficient flag per neighbour sub-block |
| nb_ref | input | 16 | Reference index per neighbour sub-block |
| nb_mvx | input | 48 | Horizontal MV per neighbour sub-block |
| nb_mvy | input | 48 | Vertical MV per neighbour sub-block |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle result strobe |
| bs_out | output | 48 | Sixteen packed 3-bit strength codes |

## Verification
A wrong edge counter or state would show as `done` arriving a cycle early or late, or as `busy` staying high. Either is visible within five cycles of `start`. A wrong P/Q selection or priority order would leave one or more wrong 3-bit slots in `bs_out` at the very `done` of the job that exposed it. A capture fault would show as results taken from data applied after `start`, visible at the next `done`. The reference model predicts `busy`, `done` and the whole of `bs_out` for every cycle. A fault therefore appears as a mismatch within one job, and the failing slot identifies the edge and segment involved.

// File: rtl/bs_pkg.sv
package bs_pkg;

    parameter int SB_SIDE  = 4;   // sub-blocks per macroblock side
    parameter int MV_W     = 12;  // motion vector component width
    parameter int REF_W    = 4;   // reference index width
    parameter int BS_W     = 3;   // strength code width
    parameter int MV_LIMIT = 4;   // quarter-sample distance that counts as motion

    localparam int SB_NUM   = SB_SIDE * SB_SIDE;
    localparam int EDGE_W   = $clog2(SB_SIDE);
    localparam int IDX_W    = 2 * EDGE_W;
    localparam int ROW_BITS = SB_SIDE * BS_W;
    localparam int OUT_BITS = SB_NUM * BS_W;

    localparam logic signed [MV_W:0] LIM_POS = (MV_W + 1)'(MV_LIMIT);
    localparam logic signed [MV_W:0] LIM_NEG = -LIM_POS;

    typedef struct packed {
        logic                    intra;
        logic                    nz;
        logic [REF_W-1:0]        ref_idx;
        logic signed [MV_W-1:0]  mvx;
        logic signed [MV_W-1:0]  mvy;
    } blk_attr_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    typedef enum logic [BS_W-1:0] {
        BS_NONE     = 3'd0,
        BS_MOTION   = 3'd1,
        BS_COEF     = 3'd2,
        BS_INTRA_IN = 3'd3,
        BS_INTRA_MB = 3'd4
    } bs_t;

    // True when two MV components are at least MV_LIMIT apart.
    function automatic logic mv_apart(input logic signed [MV_W-1:0] a,
                                      input logic signed [MV_W-1:0] b);
        logic signed [MV_W:0] diff;
        diff = $signed({a[MV_W-1], a}) - $signed({b[MV_W-1], b});
        return (diff >= LIM_POS) || (diff <= LIM_NEG);
    endfunction

endpackage

// File: rtl/bs_edge_seq.sv
module bs_edge_seq
    import bs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              accept,
    output logic              busy,
    output logic              last_edge,
    output logic [EDGE_W-1:0] edge_idx
);

    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(SB_SIDE - 1);

    seq_state_t state;

    assign busy      = (state == SEQ_RUN);
    assign accept    = start && (state == SEQ_IDLE);
    assign last_edge = busy && (edge_idx == EDGE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            edge_idx <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    edge_idx <= '0;
                    if (start) state <= SEQ_RUN;
                end
                SEQ_RUN: begin
                    if (edge_idx == EDGE_LAST) begin
                        state    <= SEQ_IDLE;
                        edge_idx <= '0;
                    end else begin
                        edge_idx <= edge_idx + EDGE_W'(1);
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    AST_ENTRY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (edge_idx == '0)); // R4
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_edge) |=> busy); // R3
    AST_RUN_ENDS: assert property (@(posedge clk) disable iff (rst)
        last_edge |=> !busy); // R2
    AST_EDGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_edge) |=> (edge_idx == $past(edge_idx) + EDGE_W'(1))); // R4

endmodule

// File: rtl/bs_pair_mux.sv
module bs_pair_mux
    import bs_pkg::*;
(
    input  logic              dir_horz,
    input  logic [EDGE_W-1:0] edge_idx,
    input  blk_attr_t         cur_blk [SB_NUM],
    input  blk_attr_t         nb_blk  [SB_SIDE],
    output blk_attr_t         p_blk   [SB_SIDE],
    output blk_attr_t         q_blk   [SB_SIDE]
);

    logic [EDGE_W-1:0] edge_prev;
    assign edge_prev = edge_idx - EDGE_W'(1);

    for (genvar s = 0; s < SB_SIDE; s++) begin : g_seg
        localparam logic [EDGE_W-1:0] SEG = EDGE_W'(s);
        logic [IDX_W-1:0] q_i;
        logic [IDX_W-1:0] p_i;

        // Index is row * SB_SIDE + column.
        always_comb begin
            if (dir_horz) begin
                q_i = {edge_idx, SEG};
                p_i = {edge_prev, SEG};
            end else begin
                q_i = {SEG, edge_idx};
                p_i = {SEG, edge_prev};
            end
            q_blk[s] = cur_blk[q_i];
            p_blk[s] = (edge_idx == '0) ? nb_blk[s] : cur_blk[p_i];
        end
    end

endmodule

// File: rtl/bs_seg_eval.sv
module bs_seg_eval
    import bs_pkg::*;
(
    input  blk_attr_t p_blk,
    input  blk_attr_t q_blk,
    input  logic      mb_edge,
    input  logic      nb_avail,
    output bs_t       strength
);

    logic any_intra;
    logic any_coef;
    logic motion;

    assign any_intra = p_blk.intra | q_blk.intra;
    assign any_coef  = p_blk.nz | q_blk.nz;
    assign motion    = (p_blk.ref_idx != q_blk.ref_idx)
                     | mv_apart(p_blk.mvx, q_blk.mvx)
                     | mv_apart(p_blk.mvy, q_blk.mvy);

    always_comb begin
        if (mb_edge && !nb_avail)  strength = BS_NONE;
        else if (any_intra)        strength = mb_edge ? BS_INTRA_MB : BS_INTRA_IN;
        else if (any_coef)         strength = BS_COEF;
        else if (motion)           strength = BS_MOTION;
        else                       strength = BS_NONE;
    end

endmodule

// File: rtl/bs_decision_unit.sv
module bs_decision_unit
    import bs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      dir,
    input  logic                      left_avail,
    input  logic                      top_avail,
    input  logic [SB_NUM-1:0]         cur_intra,
    input  logic [SB_NUM-1:0]         cur_nz,
    input  logic [SB_NUM*REF_W-1:0]   cur_ref,
    input  logic [SB_NUM*MV_W-1:0]    cur_mvx,
    input  logic [SB_NUM*MV_W-1:0]    cur_mvy,
    input  logic [SB_SIDE-1:0]        nb_intra,
    input  logic [SB_SIDE-1:0]        nb_nz,
    input  logic [SB_SIDE*REF_W-1:0]  nb_ref,
    input  logic [SB_SIDE*MV_W-1:0]   nb_mvx,
    input  logic [SB_SIDE*MV_W-1:0]   nb_mvy,
    output logic                      busy,
    output logic                      done,
    output logic [OUT_BITS-1:0]       bs_out
);

    blk_attr_t cur_in [SB_NUM];
    blk_attr_t nb_in  [SB_SIDE];
    blk_attr_t cur_q  [SB_NUM];
    blk_attr_t nb_q   [SB_SIDE];
    blk_attr_t p_sel  [SB_SIDE];
    blk_attr_t q_sel  [SB_SIDE];
    bs_t       seg_bs [SB_SIDE];

    logic              dir_q;
    logic              avail_q;
    logic              accept;
    logic              last_edge;
    logic [EDGE_W-1:0] edge_idx;
    logic [ROW_BITS-1:0] row_bits;
    logic [OUT_BITS-1:0] work_q;
    logic [OUT_BITS-1:0] work_nx;

    // Unpack port vectors into attribute records
    for (genvar i = 0; i < SB_NUM; i++) begin : g_cur
        assign cur_in[i] = {cur_intra[i], cur_nz[i],
                            cur_ref[i*REF_W +: REF_W],
                            cur_mvx[i*MV_W +: MV_W],
                            cur_mvy[i*MV_W +: MV_W]};
    end
    for (genvar j = 0; j < SB_SIDE; j++) begin : g_nb
        assign nb_in[j] = {nb_intra[j], nb_nz[j],
                           nb_ref[j*REF_W +: REF_W],
                           nb_mvx[j*MV_W +: MV_W],
                           nb_mvy[j*MV_W +: MV_W]};
    end

    // Job capture: attributes and one availability decision per job
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '{default: '0};
            nb_q    <= '{default: '0};
            dir_q   <= 1'b0;
            avail_q <= 1'b0;
        end else if (accept) begin
            cur_q   <= cur_in;
            nb_q    <= nb_in;
            dir_q   <= dir;
            avail_q <= dir ? top_avail : left_avail;
        end
    end

    bs_edge_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .accept    (accept),
        .busy      (busy),
        .last_edge (last_edge),
        .edge_idx  (edge_idx)
    );

    bs_pair_mux u_mux (
        .dir_horz (dir_q),
        .edge_idx (edge_idx),
        .cur_blk  (cur_q),
        .nb_blk   (nb_q),
        .p_blk    (p_sel),
        .q_blk    (q_sel)
    );

    for (genvar s = 0; s < SB_SIDE; s++) begin : g_eval
        bs_seg_eval u_eval (
            .p_blk    (p_sel[s]),
            .q_blk    (q_sel[s]),
            .mb_edge  (edge_idx == '0),
            .nb_avail (avail_q),
            .strength (seg_bs[s])
        );
        assign row_bits[s*BS_W +: BS_W] = seg_bs[s];
    end

    always_comb begin
        work_nx = work_q;
        work_nx[int'(edge_idx)*ROW_BITS +: ROW_BITS] = row_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            bs_out <= '0;
            done   <= 1'b0;
        end else begin
            done <= last_edge;
            if (busy)      work_q <= work_nx;
            if (last_edge) bs_out <= work_nx;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R2
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(bs_out)); // R2
    AST_BORDER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && !avail_q) |-> (bs_out[ROW_BITS-1:0] == '0)); // R10

    for (genvar k = 0; k < SB_NUM; k++) begin : g_chk
        AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
            done |-> (bs_out[k*BS_W +: BS_W] <= BS_W'(4))); // R5
        if (k >= SB_SIDE) begin : g_inner
            AST_INNER_NOT_MB: assert property (@(posedge clk) disable iff (rst)
                done |-> (bs_out[k*BS_W +: BS_W] != BS_W'(4))); // R6
        end
    end

endmodule

// File: tb/bs_decision_unit_tb.sv
module bs_decision_unit_tb;
    import bs_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, start, dir, left_avail, top_avail;
    logic [SB_NUM-1:0]        cur_intra, cur_nz;
    logic [SB_NUM*REF_W-1:0]  cur_ref;
    logic [SB_NUM*MV_W-1:0]   cur_mvx, cur_mvy;
    logic [SB_SIDE-1:0]       nb_intra, nb_nz;
    logic [SB_SIDE*REF_W-1:0] nb_ref;
    logic [SB_SIDE*MV_W-1:0]  nb_mvx, nb_mvy;
    logic busy, done;
    logic [OUT_BITS-1:0] bs_out;

    bs_decision_unit u_dut (.*);

    int c_intra [16], c_nz [16], c_ref [16], c_mvx [16], c_mvy [16];
    int n_intra [4],  n_nz [4],  n_ref [4],  n_mvx [4],  n_mvy [4];
    int t_dir, t_la, t_ta;

    int errors = 0, checks = 0, cyc = 0;
    string cur_req = "R1";
    bit checking = 0;

    // reference model state
    bit m_busy, m_done;
    int m_cnt;
    int m_bs [16];
    int m_pend [16];

    function automatic int far_apart(int a, int b);
        int d = a - b;
        return (d >= 4 || d <= -4) ? 1 : 0;
    endfunction

    function automatic int expect_code(int k);
        int e = k / 4, s = k % 4;
        int qn, pn, avail;
        int pi_, pz, pr, px, py, qi_, qz, qr, qx, qy;
        qn = t_dir ? (e * 4 + s) : (s * 4 + e);
        qi_ = c_intra[qn]; qz = c_nz[qn]; qr = c_ref[qn]; qx = c_mvx[qn]; qy = c_mvy[qn];
        if (e == 0) begin
            pi_ = n_intra[s]; pz = n_nz[s]; pr = n_ref[s]; px = n_mvx[s]; py = n_mvy[s];
        end else begin
            pn = t_dir ? ((e - 1) * 4 + s) : (s * 4 + e - 1);
            pi_ = c_intra[pn]; pz = c_nz[pn]; pr = c_ref[pn]; px = c_mvx[pn]; py = c_mvy[pn];
        end
        avail = t_dir ? t_ta : t_la;
        if (e == 0 && avail == 0) return 0;
        if (pi_ != 0 || qi_ != 0) return (e == 0) ? 4 : 3;
        if (pz != 0 || qz != 0) return 2;
        if (pr != qr || far_apart(px, qx) != 0 || far_apart(py, qy) != 0) return 1;
        return 0;
    endfunction

    task automatic push_ports();
        dir = t_dir[0]; left_avail = t_la[0]; top_avail = t_ta[0];
        for (int i = 0; i < 16; i++) begin
            cur_intra[i] = c_intra[i][0];
            cur_nz[i]    = c_nz[i][0];
            cur_ref[i*REF_W +: REF_W] = REF_W'(c_ref[i]);
            cur_mvx[i*MV_W +: MV_W]   = MV_W'(c_mvx[i]);
            cur_mvy[i*MV_W +: MV_W]   = MV_W'(c_mvy[i]);
        end
        for (int j = 0; j < 4; j++) begin
            nb_intra[j] = n_intra[j][0];
            nb_nz[j]    = n_nz[j][0];
            nb_ref[j*REF_W +: REF_W] = REF_W'(n_ref[j]);
            nb_mvx[j*MV_W +: MV_W]   = MV_W'(n_mvx[j]);
            nb_mvy[j*MV_W +: MV_W]   = MV_W'(n_mvy[j]);
        end
    endtask

    task automatic clear_attr();
        for (int i = 0; i < 16; i++) begin
            c_intra[i] = 0; c_nz[i] = 0; c_ref[i] = 0; c_mvx[i] = 0; c_mvy[i] = 0;
        end
        for (int j = 0; j < 4; j++) begin
            n_intra[j] = 0; n_nz[j] = 0; n_ref[j] = 0; n_mvx[j] = 0; n_mvy[j] = 0;
        end
        t_dir = 0; t_la = 1; t_ta = 1;
    endtask

    task automatic randomize_attr();
        for (int i = 0; i < 16; i++) begin
            c_intra[i] = ($urandom_range(0, 9) == 0) ? 1 : 0;
            c_nz[i]    = ($urandom_range(0, 5) == 0) ? 1 : 0;
            c_ref[i]   = ($urandom_range(0, 5) == 0) ? 1 : 0;
            c_mvx[i]   = int'($urandom_range(0, 12)) - 6;
            c_mvy[i]   = int'($urandom_range(0, 12)) - 6;
        end
        for (int j = 0; j < 4; j++) begin
            n_intra[j] = ($urandom_range(0, 5) == 0) ? 1 : 0;
            n_nz[j]    = ($urandom_range(0, 5) == 0) ? 1 : 0;
            n_ref[j]   = ($urandom_range(0, 5) == 0) ? 1 : 0;
            n_mvx[j]   = int'($urandom_range(0, 12)) - 6;
            n_mvy[j]   = int'($urandom_range(0, 12)) - 6;
        end
        t_dir = int'($urandom_range(0, 1));
        t_la  = ($urandom_range(0, 3) == 0) ? 0 : 1;
        t_ta  = ($urandom_range(0, 3) == 0) ? 0 : 1;
    endtask

    task automatic run_job(string req);
        cur_req = req;
        @(negedge clk);
        push_ports();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Cycle model: updated at each rising edge from the inputs driven before it
    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_done <= 0; m_cnt <= 0;
            for (int k = 0; k < 16; k++) m_bs[k] <= 0;
        end else begin
            m_done <= 0;
            if (!m_busy && start) begin
                m_busy <= 1;
                m_cnt  <= 0;
                for (int k = 0; k < 16; k++) m_pend[k] <= expect_code(k);
            end else if (m_busy) begin
                if (m_cnt == 3) begin
                    m_busy <= 0;
                    m_done <= 1;
                    for (int k = 0; k < 16; k++) m_bs[k] <= m_pend[k];
                end else begin
                    m_cnt <= m_cnt + 1;
                end
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (checking && !rst) begin
            logic [OUT_BITS-1:0] exp_vec;
            for (int k = 0; k < 16; k++) exp_vec[k*BS_W +: BS_W] = BS_W'(m_bs[k]);
            checks++;
            if (busy !== m_busy || done !== m_done) begin
                errors++;
                $display("FAIL R2: busy/done actual %b/%b expected %b/%b", busy, done, m_busy, m_done);
            end
            checks++;
            if (bs_out !== exp_vec) begin
                errors++;
                $display("FAIL %s: bs_out actual %h expected %h", cur_req, bs_out, exp_vec);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0;
        clear_attr();
        push_ports();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || bs_out !== '0) begin
            errors++;
            $display("FAIL R1: busy %b done %b bs %h expected 0 0 0", busy, done, bs_out);
        end
        checking = 1;

        // R5: boundary intra on neighbour side and on current side
        clear_attr(); n_intra[1] = 1; c_intra[0] = 1;
        run_job("R5");
        // R6: internal intra, horizontal
        clear_attr(); t_dir = 1; c_intra[5] = 1;
        run_job("R6");
        // R7: coefficients
        clear_attr(); c_nz[10] = 1; n_nz[3] = 1;
        run_job("R7");
        // R8: reference mismatch
        clear_attr(); c_ref[3] = 2; n_ref[0] = 1;
        run_job("R8");
        // R9: MV thresholds 4, 3 and -4
        clear_attr(); c_mvx[6] = 4; c_mvy[9] = -3; c_mvy[13] = -4; n_mvx[2] = 3;
        run_job("R9");
        clear_attr(); t_dir = 1; c_mvx[1] = -4; c_mvy[12] = 3;
        run_job("R9");
        // R10: left neighbour missing, vertical; other flag irrelevant
        clear_attr(); t_la = 0; t_ta = 1;
        for (int j = 0; j < 4; j++) n_intra[j] = 1;
        run_job("R10");
        clear_attr(); t_dir = 1; t_ta = 0; t_la = 1;
        for (int j = 0; j < 4; j++) begin n_intra[j] = 1; n_nz[j] = 1; end
        run_job("R10");
        clear_attr(); t_dir = 0; t_ta = 0; t_la = 1; n_intra[2] = 1;
        run_job("R10");

        // R3: start held with other data during the job
        clear_attr(); c_intra[7] = 1;
        cur_req = "R3";
        @(negedge clk);
        push_ports();
        start = 1'b1;
        @(negedge clk);
        clear_attr(); c_nz[0] = 1; t_dir = 1;
        push_ports();
        repeat (3) @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);

        // R4: mixed patterns, including back-to-back jobs
        for (int n = 0; n < 40; n++) begin
            randomize_attr();
            cur_req = "R4";
            @(negedge clk);
            push_ports();
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (($urandom_range(0, 1) == 0) ? 3 : 6) @(negedge clk);
        end
        repeat (8) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule